// File: doc/BRIEF.md
# Memory-mapped character I/O port

This block connects one character input device (keyboard-like) and one character output device (display-like) to a processor bus. Each device has a data register and a status register. The processor reaches them, and a shared control register, with ordinary single-cycle load and store transfers inside a small address window that has no memory behind it. An incoming character is latched and raises an input ready flag. The output side holds a ready flag that is set while the display can take a new character.

Both ready flags are cleared as a side effect of the data-register access itself. Reading the input data clears input ready, and writing the output data clears output ready until the display reports that it has consumed the character. A level interrupt request is raised while a ready flag and its enable bit are both set. The interrupt is therefore withdrawn by the same access that services the device.

Top module: `chario_port`

## Requirements
- R1: The window covers the addresses whose upper bits match `BASE_ADDR` (low 3 bits are the offset). Offsets: 0 input data (read), 1 input status (read), 2 output data (write), 3 output status (read), 4 control (read/write). Accesses outside the window have no effect and read as zero. Unassigned offsets read as zero, and `bus_rdata` is zero whenever `bus_re` is low.
- R2: A `kbd_valid` pulse latches `kbd_char` into input data and sets the input ready flag, which is bit 3 of the input status.
- R3: A read of input data returns the latched character and clears input ready at that clock edge.
- R4: A character that arrives while input ready is set, without an input-data read in the same cycle, sets the overrun flag (input status bit 4). It stays set until the input status is read; that read returns it as 1 and clears it.
- R5: A write of output data places the character on `disp_char`, raises `disp_valid` and clears output ready (output status bit 3) from the next cycle.
- R6: A `disp_take` pulse sets output ready again and drops `disp_valid`. If it coincides with an output-data write, the write wins and ready stays clear.
- R7: Control bit 2 enables the input interrupt and bit 3 enables the output interrupt. Both are readable, and all other control bits read as zero.
- R8: `irq` is high exactly when (input ready and bit 2) or (output ready and bit 3).
- R9: After reset, input ready and overrun are 0, output ready is 1, control is 0, `disp_valid` is 0 and `irq` is 0.
- R10: A character that arrives in the same cycle as an input-data read is kept. The read returns the older character, ready stays set and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Store data |
| bus_we | input | 1 | Store strobe, one cycle per transfer |
| bus_re | input | 1 | Load strobe, one cycle per transfer |
| bus_rdata | output | DATA_W | Load data, valid in the cycle of `bus_re` |
| kbd_valid | input | 1 | Input device delivers a character this cycle |
| kbd_char | input | DATA_W | Character from the input device |
| disp_valid | output | 1 | A character is waiting for the display |
| disp_char | output | DATA_W | Character for the display |
| disp_take | input | 1 | Display has consumed the waiting character |
| irq | output | 1 | Level interrupt request |

## Verification
A stuck or wrongly cleared ready flag shows up at the status read in the very next transfer. It also shows on `irq` in the cycle after the bad update once the matching enable is set, so the bench checks `irq` right after each data access. A lost overrun or a lost collision character only shows when the status or data is read afterwards. For that reason every scenario ends by reading back both input registers. A decode error shows as a register changing after an out-of-window store, or as non-zero load data from a miss.

// File: rtl/chario_pkg.sv
package chario_pkg;
  localparam int OFS_W   = 3;
  localparam int RDY_BIT = 3;
  localparam int OVR_BIT = 4;
  localparam int KBE_BIT = 2;
  localparam int DPE_BIT = 3;

  typedef enum logic [OFS_W-1:0] {
    SEL_RXD = 3'd0,
    SEL_RXS = 3'd1,
    SEL_TXD = 3'd2,
    SEL_TXS = 3'd3,
    SEL_CTL = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic rd_rxd;
    logic rd_rxs;
    logic rd_txs;
    logic rd_ctl;
    logic wr_txd;
    logic wr_ctl;
  } bus_strobe_t;
endpackage

// File: rtl/chario_rst_sync.sv
module chario_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/chario_decode.sv
module chario_decode
  import chario_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'hFF00
) (
  input  logic              bus_re,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output bus_strobe_t       strb
);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam logic [ADDR_W-1:0] BASE_FULL = ADDR_W'(BASE_ADDR);
  localparam logic [TAG_W-1:0]  BASE_TAG  = BASE_FULL[ADDR_W-1:OFS_W];

  logic     hit;
  reg_sel_e sel;

  always_comb begin
    hit  = (bus_addr[ADDR_W-1:OFS_W] == BASE_TAG);
    sel  = reg_sel_e'(bus_addr[OFS_W-1:0]);
    strb = '0;
    if (hit) begin
      case (sel)
        SEL_RXD: strb.rd_rxd = bus_re;
        SEL_RXS: strb.rd_rxs = bus_re;
        SEL_TXD: strb.wr_txd = bus_we;
        SEL_TXS: strb.rd_txs = bus_re;
        SEL_CTL: begin
          strb.rd_ctl = bus_re;
          strb.wr_ctl = bus_we;
        end
        default: strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/chario_rx.sv
module chario_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              kbd_valid,
  input  logic [DATA_W-1:0] kbd_char,
  input  logic              rd_data,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              rx_ovr
);
  logic              rdy_q, rdy_d;
  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;

  // Next state: arrival beats the clearing access in the same cycle.
  always_comb begin
    data_en = kbd_valid;
    rdy_d   = rdy_q;
    if (rd_data)   rdy_d = 1'b0;
    if (kbd_valid) rdy_d = 1'b1;
    ovr_d = ovr_q;
    if (rd_stat) ovr_d = 1'b0;
    if (kbd_valid && rdy_q && !rd_data) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      data_q <= '0;
    else if (data_en) data_q <= kbd_char;
  end

  assign rx_data = data_q;
  assign rx_rdy  = rdy_q;
  assign rx_ovr  = ovr_q;
endmodule

// File: rtl/chario_tx.sv
module chario_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              disp_take,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_rdy
);
  logic              rdy_q, rdy_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;

  // A new character beats a completion reported for the previous one.
  always_comb begin
    data_en = wr_data;
    rdy_d   = rdy_q;
    if (disp_take) rdy_d = 1'b1;
    if (wr_data)   rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rdy_q <= 1'b1;
    else         rdy_q <= rdy_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      data_q <= '0;
    else if (data_en) data_q <= wdata;
  end

  assign tx_data = data_q;
  assign tx_rdy  = rdy_q;
endmodule

// File: rtl/chario_port.sv
module chario_port
  import chario_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] BASE_ADDR = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbd_valid,
  input  logic [DATA_W-1:0] kbd_char,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_char,
  input  logic              disp_take,
  output logic              irq
);
  logic              srst_n;
  bus_strobe_t       strb;
  logic [DATA_W-1:0] rx_data;
  logic              rx_rdy, rx_ovr;
  logic [DATA_W-1:0] tx_data;
  logic              tx_rdy;
  logic              kbe_q, kbe_d, dpe_q, dpe_d;

  chario_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  chario_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_re(bus_re), .bus_we(bus_we), .bus_addr(bus_addr), .strb(strb)
  );

  chario_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .srst_n(srst_n), .kbd_valid(kbd_valid), .kbd_char(kbd_char),
    .rd_data(strb.rd_rxd), .rd_stat(strb.rd_rxs),
    .rx_data(rx_data), .rx_rdy(rx_rdy), .rx_ovr(rx_ovr)
  );

  chario_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .srst_n(srst_n), .wr_data(strb.wr_txd), .wdata(bus_wdata),
    .disp_take(disp_take), .tx_data(tx_data), .tx_rdy(tx_rdy)
  );

  // Control register
  always_comb begin
    kbe_d = kbe_q;
    dpe_d = dpe_q;
    if (strb.wr_ctl) begin
      kbe_d = bus_wdata[KBE_BIT];
      dpe_d = bus_wdata[DPE_BIT];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      kbe_q <= 1'b0;
      dpe_q <= 1'b0;
    end else begin
      kbe_q <= kbe_d;
      dpe_q <= dpe_d;
    end
  end

  // Load data mux; every unassigned bit stays zero
  always_comb begin
    bus_rdata = '0;
    if (strb.rd_rxd) bus_rdata = rx_data;
    if (strb.rd_rxs) begin
      bus_rdata[RDY_BIT] = rx_rdy;
      bus_rdata[OVR_BIT] = rx_ovr;
    end
    if (strb.rd_txs) bus_rdata[RDY_BIT] = tx_rdy;
    if (strb.rd_ctl) begin
      bus_rdata[KBE_BIT] = kbe_q;
      bus_rdata[DPE_BIT] = dpe_q;
    end
  end

  assign disp_valid = ~tx_rdy;
  assign disp_char  = tx_data;
  assign irq        = (rx_rdy & kbe_q) | (tx_rdy & dpe_q);
endmodule

// File: rtl/chario_chk.sv
module chario_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] BASE_ADDR = 16'hFF00
) (
  input logic              clk,
  input logic              srst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              kbd_valid,
  input logic              disp_take,
  input logic              disp_valid,
  input logic [DATA_W-1:0] disp_char,
  input logic              irq,
  input logic              rx_rdy,
  input logic              rx_ovr,
  input logic              tx_rdy,
  input logic              kbe_q,
  input logic              dpe_q
);
  localparam logic [ADDR_W-1:0] BASE_FULL = ADDR_W'(BASE_ADDR);
  logic in_win, acc_rxd, acc_rxs, acc_txd;

  always_comb begin
    in_win  = (bus_addr[ADDR_W-1:3] == BASE_FULL[ADDR_W-1:3]);
    acc_rxd = in_win && bus_re && (bus_addr[2:0] == 3'd0);
    acc_rxs = in_win && bus_re && (bus_addr[2:0] == 3'd1);
    acc_txd = in_win && bus_we && (bus_addr[2:0] == 3'd2);
  end

  a_r1_idle_rdata_zero: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_re |-> bus_rdata == '0);
  a_r2_arrival_sets_ready: assert property (@(posedge clk) disable iff (!srst_n)
    kbd_valid |=> rx_rdy);
  a_r3_read_clears_ready: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_rxd && !kbd_valid) |=> !rx_rdy);
  a_r4_overrun_flagged: assert property (@(posedge clk) disable iff (!srst_n)
    (kbd_valid && rx_rdy && !acc_rxd) |=> rx_ovr);
  a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    (rx_ovr && !acc_rxs) |=> rx_ovr);
  a_r5_write_presents: assert property (@(posedge clk) disable iff (!srst_n)
    acc_txd |=> (disp_valid && !tx_rdy && disp_char == $past(bus_wdata)));
  a_r6_take_restores: assert property (@(posedge clk) disable iff (!srst_n)
    (disp_take && !acc_txd) |=> (tx_rdy && !disp_valid));
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!srst_n)
    (!kbe_q && !dpe_q) |-> !irq);
  a_r8_irq_needs_ready: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> (rx_rdy || tx_rdy));
endmodule

bind chario_port chario_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .srst_n(srst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .kbd_valid(kbd_valid), .disp_take(disp_take), .disp_valid(disp_valid),
  .disp_char(disp_char), .irq(irq), .rx_rdy(rx_rdy), .rx_ovr(rx_ovr),
  .tx_rdy(tx_rdy), .kbe_q(kbe_q), .dpe_q(dpe_q)
);

// File: tb/sim_chario_port.sv
module sim_chario_port;
  localparam logic [15:0] BASE = 16'hFF00;
  localparam logic [15:0] A_RXD = BASE + 16'd0;
  localparam logic [15:0] A_RXS = BASE + 16'd1;
  localparam logic [15:0] A_TXD = BASE + 16'd2;
  localparam logic [15:0] A_TXS = BASE + 16'd3;
  localparam logic [15:0] A_CTL = BASE + 16'd4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, kbd_char, disp_char;
  logic       bus_we, bus_re, kbd_valid, disp_valid, disp_take, irq;
  int         checks = 0;
  int         fails  = 0;

  always #5 clk = ~clk;

  chario_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .kbd_valid(kbd_valid), .kbd_char(kbd_char), .disp_valid(disp_valid),
    .disp_char(disp_char), .disp_take(disp_take), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic kbd_send(input logic [7:0] c);
    @(negedge clk);
    kbd_valid = 1'b1; kbd_char = c;
    @(negedge clk);
    kbd_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R9 irq", {7'd0, irq}, 8'h00);
    check("R9 disp_valid", {7'd0, disp_valid}, 8'h00);
    bus_read(A_RXS, d); check("R9 input status", d, 8'h00);
    bus_read(A_TXS, d); check("R9 output status", d, 8'h08);
    bus_read(A_CTL, d); check("R9 control", d, 8'h00);
  endtask

  task automatic t_rx_basic;
    logic [7:0] d;
    kbd_send(8'h41);
    bus_read(A_RXS, d); check("R2 ready set", d, 8'h08);
    bus_read(A_RXD, d); check("R3 data", d, 8'h41);
    bus_read(A_RXS, d); check("R3 ready cleared", d, 8'h00);
  endtask

  task automatic t_overrun;
    logic [7:0] d;
    kbd_send(8'h41);
    kbd_send(8'h42);
    bus_read(A_RXD, d); check("R4 newest kept", d, 8'h42);
    kbd_send(8'h43);
    kbd_send(8'h44);
    bus_read(A_RXS, d); check("R4 overrun seen", d, 8'h18);
    bus_read(A_RXS, d); check("R4 overrun cleared by status read", d, 8'h08);
    bus_read(A_RXD, d); check("R4 data", d, 8'h44);
    bus_read(A_RXS, d); check("R4 status empty", d, 8'h00);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    kbd_send(8'h55);
    @(negedge clk);
    bus_addr = A_RXD; bus_re = 1'b1; kbd_valid = 1'b1; kbd_char = 8'h66;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0; kbd_valid = 1'b0;
    check("R10 read returns older", d, 8'h55);
    bus_read(A_RXS, d); check("R10 ready kept no overrun", d, 8'h08);
    bus_read(A_RXD, d); check("R10 new char kept", d, 8'h66);
  endtask

  task automatic t_tx;
    logic [7:0] d;
    bus_write(A_TXD, 8'h5A);
    #1;
    check("R5 disp_valid", {7'd0, disp_valid}, 8'h01);
    check("R5 disp_char", disp_char, 8'h5A);
    bus_read(A_TXS, d); check("R5 ready cleared", d, 8'h00);
    kbd_send(8'h00);
    bus_read(A_RXD, d);
    @(negedge clk); disp_take = 1'b1;
    @(negedge clk); disp_take = 1'b0;
    check("R6 disp_valid dropped", {7'd0, disp_valid}, 8'h00);
    bus_read(A_TXS, d); check("R6 ready restored", d, 8'h08);
    @(negedge clk);
    bus_addr = A_TXD; bus_wdata = 8'h33; bus_we = 1'b1; disp_take = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; disp_take = 1'b0;
    check("R6 write beats take", {7'd0, disp_valid}, 8'h01);
    check("R5 second char", disp_char, 8'h33);
    @(negedge clk); disp_take = 1'b1;
    @(negedge clk); disp_take = 1'b0;
  endtask

  task automatic t_ctrl_irq;
    logic [7:0] d;
    bus_write(A_CTL, 8'hFF);
    bus_read(A_CTL, d); check("R7 only enable bits", d, 8'h0C);
    bus_write(A_CTL, 8'h04);
    #1 check("R8 kb enabled, no char", {7'd0, irq}, 8'h00);
    kbd_send(8'h21);
    #1 check("R8 kb ready raises irq", {7'd0, irq}, 8'h01);
    bus_read(A_RXD, d);
    #1 check("R8 read drops irq", {7'd0, irq}, 8'h00);
    bus_write(A_CTL, 8'h08);
    #1 check("R8 display ready raises irq", {7'd0, irq}, 8'h01);
    bus_write(A_TXD, 8'h44);
    #1 check("R8 write drops irq", {7'd0, irq}, 8'h00);
    @(negedge clk); disp_take = 1'b1;
    @(negedge clk); disp_take = 1'b0;
    #1 check("R8 take raises irq", {7'd0, irq}, 8'h01);
    bus_write(A_CTL, 8'h00);
    #1 check("R8 masked", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_decode;
    logic [7:0] d;
    bus_write(16'hFE04, 8'h0C);
    bus_read(A_CTL, d); check("R1 miss store ignored", d, 8'h00);
    bus_write(16'hFF0C, 8'h0C);
    bus_read(A_CTL, d); check("R1 alias store ignored", d, 8'h00);
    kbd_send(8'h77);
    bus_read(16'hFE00, d); check("R1 miss load zero", d, 8'h00);
    bus_read(A_RXS, d); check("R1 miss load no side effect", d, 8'h08);
    bus_read(BASE + 16'd5, d); check("R1 unassigned offset zero", d, 8'h00);
    bus_read(A_RXD, d); check("R1 data", d, 8'h77);
    @(negedge clk); bus_addr = A_RXS;
    #2 check("R1 rdata zero without re", bus_rdata, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    kbd_valid = 1'b0; kbd_char = '0; disp_take = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_rx_basic;
    t_overrun;
    t_collision;
    t_tx;
    t_ctrl_irq;
    t_decode;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule